// File: doc/BRIEF.md
# Gated Channel Output Latch

This block keeps the on/off command for eight low-side power channels and turns it into eight registered gate-enable signals. A serial front end hands it an 8-bit command word over a valid/ready stream. Each accepted word replaces the stored state of all eight channels at once. Bit 0 of the word belongs to channel 1 and bit 7 to channel 8.

The four lowest channels can also be driven by four direct inputs, so that a host timer can modulate them for PWM. For those channels, the stored bit and the direct input are ANDed. Software can therefore force such a channel off by writing 0, and a stored 1 hands control to the direct input. A polarity pin selects whether the direct inputs count as asserted when high or when low.

The direct inputs and the polarity pin are asynchronous to the clock, so they pass through a two-flop synchroniser before the gating logic. The command stream never applies back-pressure. Ready is high whenever reset is released, and it is low only while reset is held. A word transfers on any rising clock edge where valid and ready are both high.

Top module: `chan_gate_latch`

## Requirements
- R1: While rst_n is low, every gate output is 0 and cmd_ready is 0. After rst_n is released, all eight stored bits read as 0, so every output stays off whatever the direct inputs do until a command is accepted.
- R2: On a clock edge where cmd_valid and cmd_ready are both high, cmd_data is stored. Bit i of cmd_data controls channel i+1. The gate outputs show the new word after the next rising edge, which is two edges after the handshake edge counted inclusively.
- R3: On an edge where cmd_valid is low, the stored word keeps its value and cmd_data is ignored.
- R4: For channels 5 to 8, gate_en[i] follows only the stored bit i (1 = on), whatever the direct inputs and the polarity pin do.
- R5: For channels 1 to 4, gate_en[i] is 1 only when stored bit i is 1 and direct input par_in[i] is asserted.
- R6: When pol_high is 1, a direct input counts as asserted while it is high. When pol_high is 0, it counts as asserted while it is low.
- R7: A change on par_in or pol_high that is stable before a rising edge appears on gate_en on the third rising edge, counting that edge as the first.
- R8: A stored 0 on channels 1 to 4 keeps the output off under every direct-input level and every polarity.
- R9: cmd_ready is 1 on every cycle while rst_n is high, so the stream never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Block can take a word (high out of reset) |
| cmd_data | input | 8 | Channel word, bit i = channel i+1, 1 = on |
| par_in | input | 4 | Direct PWM inputs for channels 1 to 4 |
| pol_high | input | 1 | 1 = direct inputs active high, 0 = active low |
| gate_en | output | 8 | Registered gate enables, bit i = channel i+1 |

## Verification
A command write and a direct-input edge can land in the same cycle. When they do, the gate output of a low channel depends on both the new stored bit and the newly synchronised input level. The bench provokes this by changing cmd_data, par_in and pol_high together on the same drive edge in its random phase. It judges the outcome once every pipeline has settled, against a reference built from the stored word it tracked itself. It also checks a directed case: a word that clears a channel arrives while that channel's PWM input is being asserted, and the channel must stay off.

// File: rtl/cgl_pkg.sv
package cgl_pkg;
  typedef enum logic {
    POL_ACTIVE_LOW  = 1'b0,
    POL_ACTIVE_HIGH = 1'b1
  } par_pol_e;
endpackage

// File: rtl/cgl_sync.sv
module cgl_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cgl_cmd_store.sv
module cgl_cmd_store #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [NCH-1:0] cmd_data,
  output logic [NCH-1:0] state_q
);
  assign cmd_ready = rst_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      state_q <= '0;
    else if (cmd_valid && cmd_ready) state_q <= cmd_data;

  a_r2_load_word: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (state_q == $past(cmd_data)));

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(state_q));
endmodule

// File: rtl/cgl_gate.sv
module cgl_gate
  import cgl_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int NPAR = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  state_q,
  input  logic [NPAR-1:0] par_s,
  input  logic            pol_s,
  output logic [NCH-1:0]  gate_q
);
  logic [NCH-1:0]  gate_d;
  logic [NPAR-1:0] par_act;

  assign par_act = (par_pol_e'(pol_s) == POL_ACTIVE_HIGH) ? par_s : ~par_s;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      if (i < NPAR) begin : g_gated
        assign gate_d[i] = state_q[i] & par_act[i];
      end else begin : g_plain
        assign gate_d[i] = state_q[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gate_q <= '0;
    else        gate_q <= gate_d;

  a_r1_off_in_reset: assert property (@(posedge clk)
    !rst_n |-> (gate_q == '0));

  a_r8_zero_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_q[NPAR-1:0] & ~$past(state_q[NPAR-1:0])) == '0));

  a_r4_upper_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q[NCH-1:NPAR] == $past(state_q[NCH-1:NPAR])));
endmodule

// File: rtl/chan_gate_latch.sv
module chan_gate_latch #(
  parameter int NCH         = 8,
  parameter int NPAR        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [NCH-1:0]  cmd_data,
  input  logic [NPAR-1:0] par_in,
  input  logic            pol_high,
  output logic [NCH-1:0]  gate_en
);
  localparam int SW = NPAR + 1;

  logic [NCH-1:0] state_q;
  logic [SW-1:0]  sync_q;

  cgl_cmd_store #(.NCH(NCH)) u_store (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .state_q(state_q)
  );

  cgl_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async({pol_high, par_in}), .q_sync(sync_q)
  );

  cgl_gate #(.NCH(NCH), .NPAR(NPAR)) u_gate (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .par_s(sync_q[NPAR-1:0]),
    .pol_s(sync_q[NPAR]), .gate_q(gate_en)
  );

  a_r9_ready_up: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en[0]) |-> cmd_ready);
endmodule

// File: tb/chan_gate_latch_test.sv
module chan_gate_latch_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_data = '0;
  logic [3:0] par_in = '0;
  logic       pol_high = 1'b1;
  logic [7:0] gate_en;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] model_word = '0;
  bit done = 0;

  always #10 clk = ~clk;

  chan_gate_latch uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .par_in(par_in), .pol_high(pol_high), .gate_en(gate_en)
  );

  function automatic logic [7:0] expect_gate(logic [7:0] w, logic [3:0] p, logic pol);
    logic [3:0] act = pol ? p : ~p;
    return {w[7:4], w[3:0] & act};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic send(logic [7:0] w);
    cmd_data = w; cmd_valid = 1'b1;
    tick(1);
    cmd_valid = 1'b0;
    model_word = w;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    tick(3);
    // R1: reset state
    chk("R1 gate in reset", gate_en, 8'h00);
    chk("R1 ready in reset", {7'd0, cmd_ready}, 8'h00);
    rst_n = 1'b1; par_in = 4'hF; pol_high = 1'b1;
    tick(5);
    chk("R1 cleared after reset", gate_en, 8'h00);
    chk("R9 ready high", {7'd0, cmd_ready}, 8'h01);

    // R2 latency: handshake edge, then output on the next edge
    cmd_data = 8'hA5; cmd_valid = 1'b1;
    tick(1); cmd_valid = 1'b0; model_word = 8'hA5;
    chk("R2 not yet visible", gate_en, 8'h00);
    tick(1);
    chk("R2 word visible", gate_en, 8'hA5);

    // R3: data with valid low ignored
    cmd_data = 8'h3C; tick(4);
    chk("R3 idle data ignored", gate_en, 8'hA5);

    // R7 latency of a direct input edge
    send(8'hFF); par_in = 4'h0; tick(5);
    chk("R5 inputs deasserted", gate_en, 8'hF0);
    par_in = 4'h1;
    tick(2);
    chk("R7 two edges not yet", gate_en, 8'hF0);
    tick(1);
    chk("R7 third edge", gate_en, 8'hF1);

    // R6 polarity flip
    pol_high = 1'b0; tick(4);
    chk("R6 active low", gate_en, 8'hFE);

    // R8: clear low channels while direct inputs asserted
    par_in = 4'h0; cmd_data = 8'h80; cmd_valid = 1'b1;
    tick(1); cmd_valid = 1'b0; model_word = 8'h80;
    tick(4);
    chk("R8 stored zero forces off", gate_en, 8'h80);
    pol_high = 1'b1; par_in = 4'hF; tick(4);
    chk("R8 zero off other polarity", gate_en, 8'h80);

    // R4: upper channels independent of direct inputs
    send(8'h50); par_in = 4'h0; pol_high = 1'b1; tick(4);
    chk("R4 upper follow word", gate_en, 8'h50);

    // random mix, command and input changes in the same cycle
    for (int it = 0; it < 300; it++) begin
      logic v = $urandom() % 2;
      cmd_data = $urandom(); par_in = $urandom(); pol_high = $urandom();
      cmd_valid = v;
      tick(1);
      cmd_valid = 1'b0;
      if (v) model_word = cmd_data;
      tick(4);
      chk("R5 R6 random", gate_en, expect_gate(model_word, par_in, pol_high));
      chk("R9 random ready", {7'd0, cmd_ready}, 8'h01);
    end

    // R1 mid-run reset
    send(8'hFF); par_in = 4'hF; pol_high = 1'b1; tick(4);
    rst_n = 1'b0; tick(1);
    chk("R1 reset mid run", gate_en, 8'h00);
    rst_n = 1'b1; tick(5);
    chk("R1 word cleared", gate_en, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule